// File: doc/BRIEF.md
# Serial GPIO Shift Engine

This block carries a configurable number of general-purpose pins over one shared clocked chain to external shift registers. Each serial pin has two directions: an output bit that the host places on a parallel output bus and an input bit that comes back from the far side. Once per frame the engine sends out every output bit, collects every input bit and then updates a parallel input register for the host to read.

A 32-bit control word drives the engine. Bit 0 turns it on. A group field that starts at bit 6 gives the number of pins in units of eight. Bits 31:16 hold a 16-bit divider D, and the serial clock is high and low for D+1 system clocks each. The block samples the control word only at frame boundaries, so the host can rewrite it at any moment without breaking a frame in progress.

Top module: `sgp_shift_engine`

## Requirements
- R1: Out of reset the serial clock, the load strobe and the serial data output are low, and the parallel input register reads zero.
- R2: While control bit 0 is clear, or while the group field (bits 6 up, GRP_W wide) is zero, the engine stays idle: no serial clock edge and no load strobe.
- R3: The serial clock stays low for exactly D+1 system clocks and then high for exactly D+1 system clocks, where D is control bits 31:16. A frame therefore lasts 2·N·(D+1) system clocks.
- R4: A frame holds exactly N serial clock cycles, where N is eight times the group field.
- R5: Each frame begins with a load strobe that is high for exactly one system clock while the serial clock is low.
- R6: During serial cycle k (k = 0 first), the serial data output carries bit k of the output bus as it was captured in the load cycle. It changes only on a falling serial clock edge. Changes to the output bus after the load cycle have no effect until the next frame.
- R7: The serial input is sampled at the rising serial clock edge of cycle k into bit k of the parallel input register. Bits at N and above read zero.
- R8: The parallel input register changes only at the end of a complete frame, on the final falling serial clock edge, so a partial frame is never visible.
- R9: A new control word takes effect at the next frame boundary. If the enable is cleared mid-frame, the current frame still completes and updates the input register, and after that no further frame begins.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctrl_word | input | 32 | Control: bit 0 enable, bits 6 up group count, bits 31:16 divider |
| out_bits | input | MAX_PINS | Parallel output bits to be shifted out |
| in_bits | output | MAX_PINS | Parallel input register, updated per complete frame |
| ser_clk | output | 1 | Serial shift clock to the external chain |
| ser_load | output | 1 | One-cycle strobe at the start of each frame |
| ser_dout | output | 1 | Serial output data |
| ser_din | input | 1 | Serial input data |

MAX_PINS is 8·(2^GRP_W − 1).

## Verification
The main function is exercised over every pin count of a two-bit group field, each combined with divider values 0, 1 and 3. Divider 0 distinguishes an off-by-one in the half-period count, because any extra cycle doubles the length. The bench drives fresh random patterns on the output bus and the serial input in every frame, and it changes the output bus right after each load strobe. A random pattern makes a bit-order reversal or a shifted index visible, and the mid-frame change shows whether the snapshot was taken at the load cycle. The control word is also rewritten just after each frame start, and the enable is finally cleared mid-frame, which shows whether the old configuration governs the frame already running.

// File: rtl/sgp_pkg.sv
package sgp_pkg;
    // Control word field positions (decoded by software-visible layout)
    localparam int CTL_EN_BIT  = 0;
    localparam int CTL_GRP_LSB = 6;
    localparam int CTL_DIV_LSB = 16;
    localparam int CTL_DIV_W   = 16;

    typedef logic [CTL_DIV_W-1:0] div_t;
endpackage

// File: rtl/sgp_half_timer.sv
module sgp_half_timer
    import sgp_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic hold,
    input  div_t div,
    output logic tick
);
    typedef struct packed {
        div_t cnt;
    } tmr_t;

    tmr_t st_d, st_q;

    assign tick = !hold && (st_q.cnt == div);

    always_comb begin
        st_d = st_q;
        if (hold || tick) begin
            st_d.cnt = '0;
        end else begin
            st_d.cnt = st_q.cnt + div_t'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    AST_HALF_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        !hold |-> (st_q.cnt <= div)); // R3
endmodule

// File: rtl/sgp_frame_ctrl.sv
module sgp_frame_ctrl
    import sgp_pkg::*;
#(
    parameter int GRP_W = 4,
    localparam int IDX_W = GRP_W + 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [31:0]      ctrl_word,
    input  logic             tick,
    output logic             run,
    output logic             sclk,
    output logic             load,
    output logic [IDX_W-1:0] idx,
    output logic             start,
    output logic             rise,
    output logic             fend,
    output div_t             div
);
    typedef struct packed {
        logic             run;
        logic             sclk;
        logic             load;
        logic [IDX_W-1:0] idx;
        logic [GRP_W-1:0] grp;
        div_t             div;
    } fsm_t;

    fsm_t st_d, st_q;

    logic [GRP_W-1:0] ctl_grp;
    div_t             ctl_div;
    logic             cfg_ok;
    logic [IDX_W-1:0] last_idx;
    logic             ctrl_unused;

    assign ctl_grp     = ctrl_word[CTL_GRP_LSB +: GRP_W];
    assign ctl_div     = ctrl_word[CTL_DIV_LSB +: CTL_DIV_W];
    assign cfg_ok      = ctrl_word[CTL_EN_BIT] && (ctl_grp != '0);
    assign last_idx    = {st_q.grp, 3'b000} - IDX_W'(1);
    assign ctrl_unused = ^{ctrl_word[CTL_DIV_LSB-1:CTL_GRP_LSB+GRP_W],
                           ctrl_word[CTL_GRP_LSB-1:CTL_EN_BIT+1]};

    always_comb begin
        st_d      = st_q;
        st_d.load = 1'b0;
        start     = 1'b0;
        rise      = 1'b0;
        fend      = 1'b0;
        if (!st_q.run) begin
            start = cfg_ok;
        end else if (tick) begin
            if (!st_q.sclk) begin
                st_d.sclk = 1'b1;
                rise      = 1'b1;
            end else begin
                st_d.sclk = 1'b0;
                if (st_q.idx == last_idx) begin
                    fend = 1'b1;
                    if (cfg_ok) start = 1'b1;
                    else        st_d.run = 1'b0;
                end else begin
                    st_d.idx = st_q.idx + IDX_W'(1);
                end
            end
        end
        if (start) begin
            st_d.run  = 1'b1;
            st_d.sclk = 1'b0;
            st_d.idx  = '0;
            st_d.load = 1'b1;
            st_d.grp  = ctl_grp;
            st_d.div  = ctl_div;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign run  = st_q.run;
    assign sclk = st_q.sclk;
    assign load = st_q.load;
    assign idx  = st_q.idx;
    assign div  = st_q.div;

    AST_LOAD_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.load |=> !st_q.load); // R5
    AST_LOAD_CLK_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.load |-> !st_q.sclk); // R5
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !st_q.run |-> (!st_q.sclk && !st_q.load)); // R2
    AST_IDX_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.run |-> (st_q.idx <= last_idx)); // R4
    AST_CFG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.run && !st_q.load) |-> ($stable(st_q.div) && $stable(st_q.grp))); // R9
endmodule

// File: rtl/sgp_data_path.sv
module sgp_data_path #(
    parameter int MAX_PINS = 120,
    parameter int IDX_W    = 7
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                run,
    input  logic                start,
    input  logic                rise,
    input  logic                fend,
    input  logic [IDX_W-1:0]    idx,
    input  logic [MAX_PINS-1:0] out_bits,
    input  logic                ser_din,
    output logic                ser_dout,
    output logic [MAX_PINS-1:0] in_bits
);
    typedef struct packed {
        logic [MAX_PINS-1:0] osnap;
        logic [MAX_PINS-1:0] cap;
        logic [MAX_PINS-1:0] inreg;
    } dp_t;

    dp_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (rise)  st_d.cap[idx] = ser_din;
        if (fend)  st_d.inreg    = st_q.cap;
        if (start) begin
            st_d.osnap = out_bits;
            st_d.cap   = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ser_dout = run ? st_q.osnap[idx] : 1'b0;
    assign in_bits  = st_q.inreg;

    AST_IN_AT_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(st_q.inreg) |-> $past(fend)); // R8
endmodule

// File: rtl/sgp_shift_engine.sv
module sgp_shift_engine
    import sgp_pkg::*;
#(
    parameter int GRP_W = 4,
    localparam int IDX_W    = GRP_W + 3,
    localparam int MAX_PINS = 8 * ((1 << GRP_W) - 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [31:0]         ctrl_word,
    input  logic [MAX_PINS-1:0] out_bits,
    output logic [MAX_PINS-1:0] in_bits,
    output logic                ser_clk,
    output logic                ser_load,
    output logic                ser_dout,
    input  logic                ser_din
);
    logic             run, tick, start, rise, fend;
    logic [IDX_W-1:0] idx;
    div_t             div;

    sgp_half_timer u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .hold  (!run),
        .div   (div),
        .tick  (tick)
    );

    sgp_frame_ctrl #(.GRP_W(GRP_W)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .ctrl_word (ctrl_word),
        .tick      (tick),
        .run       (run),
        .sclk      (ser_clk),
        .load      (ser_load),
        .idx       (idx),
        .start     (start),
        .rise      (rise),
        .fend      (fend),
        .div       (div)
    );

    sgp_data_path #(.MAX_PINS(MAX_PINS), .IDX_W(IDX_W)) u_data (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (run),
        .start    (start),
        .rise     (rise),
        .fend     (fend),
        .idx      (idx),
        .out_bits (out_bits),
        .ser_din  (ser_din),
        .ser_dout (ser_dout),
        .in_bits  (in_bits)
    );

    AST_DOUT_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (ser_clk && $past(ser_clk)) |-> $stable(ser_dout)); // R6
endmodule

// File: tb/sgp_shift_engine_test.sv
module sgp_shift_engine_test;
    localparam int GW = 2;
    localparam int MP = 8 * ((1 << GW) - 1);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [31:0]   ctrl_word = '0;
    logic [MP-1:0] out_bits = '0;
    logic [MP-1:0] in_bits;
    logic          ser_clk, ser_load, ser_dout;
    logic          ser_din = 1'b0;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    always #5 clk = ~clk;

    sgp_shift_engine #(.GRP_W(GW)) uut (
        .clk(clk), .rst_n(rst_n), .ctrl_word(ctrl_word), .out_bits(out_bits),
        .in_bits(in_bits), .ser_clk(ser_clk), .ser_load(ser_load),
        .ser_dout(ser_dout), .ser_din(ser_din)
    );

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] mk(input int en, input int g, input int d);
        logic [31:0] w;
        w = '0;
        w[0] = en[0];
        w[6 +: GW] = g[GW-1:0];
        w[31:16] = d[15:0];
        return w;
    endfunction

    function automatic logic [MP-1:0] rnd();
        return MP'({$urandom, $urandom});
    endfunction

    task automatic watch_idle(input int cyc, output int activity);
        activity = 0;
        for (int i = 0; i < cyc; i++) begin
            @(negedge clk);
            if (ser_clk || ser_load) activity++;
        end
    endtask

    // Starts at a negedge where ser_load is high; ends at next such negedge or at lim.
    task automatic run_frame(input logic [MP-1:0] pat, input int lim,
                             output int period, output int hicnt, output int rises,
                             output logic [MP-1:0] seen, output bit inb_changed);
        logic          prev;
        logic [MP-1:0] in0;
        period = 0; hicnt = 0; rises = 0; seen = '0; prev = 1'b0;
        in0 = in_bits; inb_changed = 0;
        ser_din = pat[0];
        forever begin
            @(negedge clk);
            period++;
            if (ser_load || period > lim) break;
            if (in_bits !== in0) inb_changed = 1;
            if (ser_clk) hicnt++;
            if (ser_clk && !prev) begin
                if (rises < MP) seen[rises] = ser_dout;
                rises++;
            end
            prev = ser_clk;
            ser_din = (rises < MP) ? pat[rises] : 1'b0;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        int cg[9];
        int cd[9];
        int act, period, hicnt, rises, n, d, lim;
        bit chg, got;
        logic [MP-1:0] seen, pat, mask, out_prev, out_cur;

        cg = '{1, 1, 2, 2, 3, 3, 1, 3, 2};
        cd = '{0, 1, 0, 3, 1, 0, 3, 3, 1};

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(ser_clk == 1'b0, "R1 ser_clk", ser_clk, 0);
        chk(ser_load == 1'b0, "R1 ser_load", ser_load, 0);
        chk(ser_dout == 1'b0, "R1 ser_dout", ser_dout, 0);
        chk(in_bits == '0, "R1 in_bits", in_bits, 0);

        // R2 enable clear, then zero groups
        ctrl_word = mk(0, 2, 0);
        watch_idle(40, act);
        chk(act == 0, "R2 enable clear", act, 0);
        ctrl_word = mk(1, 0, 0);
        watch_idle(40, act);
        chk(act == 0, "R2 zero groups", act, 0);

        out_cur = rnd();
        out_bits = out_cur;
        ctrl_word = mk(1, cg[0], cd[0]);
        got = 0;
        for (int i = 0; i < 10 && !got; i++) begin
            @(negedge clk);
            if (ser_load) got = 1;
        end
        chk(got, "R5 first load", got, 1);

        for (int i = 0; i < 9; i++) begin
            n = 8 * cg[i];
            d = cd[i];
            lim = 2 * n * (d + 1) + 8;
            mask = (n >= MP) ? '1 : ((MP'(1) << n) - MP'(1));
            // R9: new control written after the frame has begun
            ctrl_word = (i < 8) ? mk(1, cg[i+1], cd[i+1]) : mk(0, 1, 0);
            pat = rnd();
            out_prev = out_cur;
            out_cur = rnd();
            out_bits = out_cur; // R6: ignored for the current frame
            run_frame(pat, lim, period, hicnt, rises, seen, chg);
            if (i < 8) begin
                chk(period == 2 * n * (d + 1), "R3 frame length", period, 2 * n * (d + 1));
                chk(hicnt == n * (d + 1), "R3 high time", hicnt, n * (d + 1));
                chk(rises == n, "R4 serial cycles", rises, n);
                chk((seen & mask) == (out_prev & mask), "R6 serial out", seen & mask, out_prev & mask);
                chk(in_bits == (pat & mask), "R7 parallel in", in_bits, pat & mask);
                chk(!chg, "R8 no partial update", chg, 0);
            end else begin
                chk(period > lim, "R9 no frame after disable", period, lim + 1);
                chk(rises == n, "R9 frame completes", rises, n);
                chk(in_bits == (pat & mask), "R9 final in_bits", in_bits, pat & mask);
                watch_idle(40, act);
                chk(act == 0, "R2 idle after disable", act, 0);
            end
        end

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule